// File: doc/BRIEF.md
# Request-Acknowledge Latency Window Monitor

This block sits beside a single-bit request/acknowledge pair and times every request. When a request is sampled while nothing is outstanding, a cycle counter starts; the acknowledge is then classified as arriving too early, inside the permitted window, or not at all before the window closes. Each verdict is a single-cycle pulse. Error verdicts also set a sticky flag that only a synchronous reset clears.

Only one request is tracked at a time. A fresh request raised while one is still waiting is reported as an overlap. An end-of-test input turns the check into a strong one: any request still outstanding when the input is raised is reported as an unmet obligation. The window bounds are parameters. A static output shows whether the bounds are inconsistent.

Top module: `lat_window_mon`

## Requirements
- R1: A request sampled high at a rising edge while no request is outstanding starts timing. The edge k rising edges later is window cycle k, counting from k = 1.
- R2: An acknowledge sampled at window cycle k with MIN_LAT <= k <= MAX_LAT produces a one-cycle `pass_o` pulse in the cycle after that edge. The request is then closed.
- R3: An acknowledge sampled at window cycle k < MIN_LAT produces a one-cycle `early_o` pulse in the cycle after that edge. The request is then closed.
- R4: When window cycle MAX_LAT is sampled with no acknowledge, a one-cycle `late_o` pulse follows in the next cycle. The request is then dropped.
- R5: A request sampled while one is outstanding, with no acknowledge at that edge, produces a one-cycle `overlap_o` pulse. Timing of the original request continues unchanged. A request sampled together with the acknowledge that closes the outstanding one starts a new timing window.
- R6: `eot_i` sampled high while a request is outstanding and unresolved at that edge produces a one-cycle `unmet_o` pulse. `eot_i` has no effect when nothing is outstanding.
- R7: An acknowledge sampled while no request is outstanding produces no pulse and leaves `sticky_err_o` unchanged.
- R8: `sticky_err_o` rises together with any `early_o`, `late_o`, `overlap_o` or `unmet_o` pulse and stays high until reset. `pass_o` never sets it.
- R9: `cfg_bad_o` is high exactly when MAX_LAT < MIN_LAT. It is 0 for the default window of 2 to 4.
- R10: While `rst` is sampled high, all pulse outputs and `sticky_err_o` are 0 in the following cycle, and any outstanding request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request being monitored |
| ack_i | input | 1 | Acknowledge being monitored |
| eot_i | input | 1 | End of test; report any outstanding request |
| pass_o | output | 1 | Acknowledge arrived inside the window |
| early_o | output | 1 | Acknowledge arrived before MIN_LAT |
| late_o | output | 1 | No acknowledge by MAX_LAT |
| overlap_o | output | 1 | Second request while one is outstanding |
| unmet_o | output | 1 | Request outstanding at end of test |
| sticky_err_o | output | 1 | Any error seen since reset |
| cfg_bad_o | output | 1 | Window parameters inconsistent |

## Verification
On every cycle the bound checker confirms the following:
- At most one verdict pulses at a time.
- Each verdict agrees with the acknowledge level and the count at the deciding edge.
- The counter stays inside the window while a request is outstanding.
- The sticky flag never falls and always accompanies an error pulse.
- A lone acknowledge while idle produces no pulse.

Other properties depend on a whole stimulus sequence, so only the bench scenarios can show them. These are: exact pass/early boundaries at window cycles 1, 2 and 4; late expiry; an overlapping request followed by a valid acknowledge; a back-to-back request on the acknowledging edge; and the end-of-test report.

// File: rtl/lat_pkg.sv
package lat_pkg;

    typedef enum logic [1:0] {
        VERD_NONE  = 2'd0,
        VERD_PASS  = 2'd1,
        VERD_EARLY = 2'd2,
        VERD_LATE  = 2'd3
    } verdict_e;

    typedef struct packed {
        logic pass;
        logic early;
        logic late;
        logic overlap;
        logic unmet;
    } report_t;

    // counter must hold MAX+1 for saturation
    function automatic int cnt_bits(input int max_lat);
        return $clog2(max_lat + 2);
    endfunction

endpackage

// File: rtl/lat_window_ctr.sv
module lat_window_ctr #(
    parameter int MAX_LAT = 4,
    parameter int CW      = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          stop_i,
    output logic          busy_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] CNT_TOP = CW'(MAX_LAT + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            cnt_o  <= '0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            cnt_o  <= CW'(1);
        end else if (stop_i) begin
            busy_o <= 1'b0;
            cnt_o  <= '0;
        end else if (busy_o && cnt_o < CNT_TOP) begin
            cnt_o  <= cnt_o + CW'(1);
        end
    end
endmodule

// File: rtl/lat_classify.sv
module lat_classify
    import lat_pkg::*;
#(
    parameter int MIN_LAT = 2,
    parameter int MAX_LAT = 4,
    parameter int CW      = 3
) (
    input  logic          busy_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          req_i,
    input  logic          ack_i,
    input  logic          eot_i,
    output verdict_e      verdict_o,
    output logic          overlap_o,
    output logic          unmet_o
);
    int cnt_v;

    always_comb begin
        cnt_v     = 32'(cnt_i);
        verdict_o = VERD_NONE;
        if (busy_i) begin
            if (ack_i) begin
                verdict_o = (cnt_v < MIN_LAT) ? VERD_EARLY : VERD_PASS;
            end else if (cnt_v >= MAX_LAT) begin
                verdict_o = VERD_LATE;
            end
        end
        overlap_o = busy_i && req_i && !ack_i;
        unmet_o   = busy_i && eot_i && (verdict_o == VERD_NONE);
    end
endmodule

// File: rtl/lat_report_reg.sv
module lat_report_reg
    import lat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_e verdict_i,
    input  logic     overlap_i,
    input  logic     unmet_i,
    output report_t  rep_o,
    output logic     sticky_o
);
    report_t rep_d;

    always_comb begin
        rep_d.pass    = (verdict_i == VERD_PASS);
        rep_d.early   = (verdict_i == VERD_EARLY);
        rep_d.late    = (verdict_i == VERD_LATE);
        rep_d.overlap = overlap_i;
        rep_d.unmet   = unmet_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rep_o    <= '0;
            sticky_o <= 1'b0;
        end else begin
            rep_o    <= rep_d;
            sticky_o <= sticky_o | rep_d.early | rep_d.late | rep_d.overlap | rep_d.unmet;
        end
    end
endmodule

// File: rtl/lat_window_mon.sv
module lat_window_mon
    import lat_pkg::*;
#(
    parameter int MIN_LAT = 2,
    parameter int MAX_LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic ack_i,
    input  logic eot_i,
    output logic pass_o,
    output logic early_o,
    output logic late_o,
    output logic overlap_o,
    output logic unmet_o,
    output logic sticky_err_o,
    output logic cfg_bad_o
);
    localparam int CW = cnt_bits(MAX_LAT);

    logic          busy;
    logic [CW-1:0] cnt;
    logic          start;
    logic          stop;
    verdict_e      verdict;
    logic          ovl_d;
    logic          unmet_d;
    report_t       rep;

    assign start = req_i && (!busy || ack_i);
    assign stop  = (verdict != VERD_NONE);

    lat_window_ctr #(.MAX_LAT(MAX_LAT), .CW(CW)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .stop_i  (stop),
        .busy_o  (busy),
        .cnt_o   (cnt)
    );

    lat_classify #(.MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT), .CW(CW)) u_cls (
        .busy_i    (busy),
        .cnt_i     (cnt),
        .req_i     (req_i),
        .ack_i     (ack_i),
        .eot_i     (eot_i),
        .verdict_o (verdict),
        .overlap_o (ovl_d),
        .unmet_o   (unmet_d)
    );

    lat_report_reg u_rep (
        .clk       (clk),
        .rst       (rst),
        .verdict_i (verdict),
        .overlap_i (ovl_d),
        .unmet_i   (unmet_d),
        .rep_o     (rep),
        .sticky_o  (sticky_err_o)
    );

    assign pass_o    = rep.pass;
    assign early_o   = rep.early;
    assign late_o    = rep.late;
    assign overlap_o = rep.overlap;
    assign unmet_o   = rep.unmet;
    assign cfg_bad_o = (MAX_LAT < MIN_LAT);
endmodule

// File: rtl/lat_window_mon_chk.sv
module lat_window_mon_chk #(
    parameter int MIN_LAT = 2,
    parameter int MAX_LAT = 4,
    parameter int CW      = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          req_i,
    input logic          ack_i,
    input logic          busy,
    input logic [CW-1:0] cnt,
    input logic          pass_o,
    input logic          early_o,
    input logic          late_o,
    input logic          overlap_o,
    input logic          unmet_o,
    input logic          sticky_err_o
);
    // R2 R3 R4
    verdict_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pass_o, early_o, late_o}));

    // R2
    pass_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && ack_i && 32'(cnt) >= MIN_LAT) |=> pass_o);

    // R3
    early_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && ack_i && 32'(cnt) < MIN_LAT) |=> early_o);

    // R4
    late_without_ack_chk: assert property (@(posedge clk) disable iff (rst)
        late_o |-> !$past(ack_i));

    // R1
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt >= CW'(1) && 32'(cnt) <= MAX_LAT));

    // R7
    idle_ack_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && ack_i && !req_i) |=> !(pass_o || early_o || late_o || overlap_o || unmet_o));

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sticky_err_o |=> sticky_err_o);

    // R8
    sticky_follows_err_chk: assert property (@(posedge clk) disable iff (rst)
        (early_o || late_o || overlap_o || unmet_o) |-> sticky_err_o);

    // R5
    overlap_cause_chk: assert property (@(posedge clk) disable iff (rst)
        overlap_o |-> ($past(req_i) && !$past(ack_i)));
endmodule

bind lat_window_mon lat_window_mon_chk #(
    .MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT), .CW(CW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req_i),
    .ack_i        (ack_i),
    .busy         (busy),
    .cnt          (cnt),
    .pass_o       (pass_o),
    .early_o      (early_o),
    .late_o       (late_o),
    .overlap_o    (overlap_o),
    .unmet_o      (unmet_o),
    .sticky_err_o (sticky_err_o)
);

// File: tb/test_lat_window_mon.sv
module test_lat_window_mon;
    localparam int MIN_LAT = 2;
    localparam int MAX_LAT = 4;

    // result codes: 1 pass, 2 early, 3 late, 4 overlap, 5 unmet
    localparam int C_PASS = 1, C_EARLY = 2, C_LATE = 3, C_OVL = 4, C_UNMET = 5;

    logic clk = 0;
    logic rst = 1;
    logic req = 0, ack = 0, eot = 0;
    logic pass_o, early_o, late_o, overlap_o, unmet_o, sticky_err_o, cfg_bad_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int exp_q[$];

    always #5 clk = ~clk;

    lat_window_mon #(.MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT)) i_lat_window_mon (
        .clk(clk), .rst(rst), .req_i(req), .ack_i(ack), .eot_i(eot),
        .pass_o(pass_o), .early_o(early_o), .late_o(late_o),
        .overlap_o(overlap_o), .unmet_o(unmet_o),
        .sticky_err_o(sticky_err_o), .cfg_bad_o(cfg_bad_o)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected results as pulses appear
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && !done) begin
                int code;
                int n;
                n = int'(pass_o) + int'(early_o) + int'(late_o) + int'(overlap_o) + int'(unmet_o);
                code = pass_o ? C_PASS : early_o ? C_EARLY : late_o ? C_LATE :
                       overlap_o ? C_OVL : unmet_o ? C_UNMET : 0;
                if (n > 1) check(n, 1, "R2 single pulse");
                if (code != 0) begin
                    if (exp_q.size() == 0) check(code, 0, "R7 unexpected pulse");
                    else check(code, exp_q.pop_front(), "R2/R3/R4/R5/R6 verdict");
                end
            end
        end
    end

    // request at the coming edge, ack at window cycle k (k=0 means none)
    task automatic drive_req(input int k, input int exp_code);
        exp_q.push_back(exp_code);
        @(negedge clk);
        req = 1;
        for (int i = 1; i <= MAX_LAT + 1; i++) begin
            @(negedge clk);
            if (i == 1) req = 0;
            ack = (i == k);
        end
        ack = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R10 reset state, R9 default config
        check({pass_o, early_o, late_o, overlap_o, unmet_o}, 0, "R10 pulses after reset");
        check(sticky_err_o, 0, "R10 sticky after reset");
        check(cfg_bad_o, 0, "R9 default window valid");

        // R1 R2 window boundaries
        drive_req(MIN_LAT, C_PASS);
        drive_req(3, C_PASS);
        drive_req(MAX_LAT, C_PASS);

        // R7 lone ack while idle
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0;
        @(negedge clk);
        check(exp_q.size(), 0, "R7 idle ack queue");
        // R6 eot while idle has no effect
        eot = 1; @(negedge clk); eot = 0; @(negedge clk);
        check(sticky_err_o, 0, "R8 pass and idle leave sticky clear");

        // R3 early
        drive_req(1, C_EARLY);
        check(sticky_err_o, 1, "R8 sticky after early");
        repeat (3) @(negedge clk);
        check(sticky_err_o, 1, "R8 sticky holds");
        do_reset();
        check(sticky_err_o, 0, "R10 reset clears sticky");

        // R4 late
        drive_req(0, C_LATE);
        check(sticky_err_o, 1, "R8 sticky after late");
        do_reset();

        // R5 overlap: second req at cycle 2, ack at cycle 3 -> overlap then pass
        exp_q.push_back(C_OVL);
        exp_q.push_back(C_PASS);
        @(negedge clk); req = 1;
        @(negedge clk); req = 0;
        @(negedge clk); req = 1;
        @(negedge clk); req = 0; ack = 1;
        @(negedge clk); ack = 0;
        repeat (3) @(negedge clk);
        check(exp_q.size(), 0, "R5 overlap sequence consumed");
        do_reset();

        // R5 back-to-back: ack+req at cycle 3, new ack 2 cycles later
        exp_q.push_back(C_PASS);
        exp_q.push_back(C_PASS);
        @(negedge clk); req = 1;
        @(negedge clk); req = 0;
        @(negedge clk);
        @(negedge clk); req = 1; ack = 1;
        @(negedge clk); req = 0; ack = 0;
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0;
        repeat (3) @(negedge clk);
        check(sticky_err_o, 0, "R5 restart on ack raises no error");

        // R6 eot at cycle 2 then ack at 3 -> unmet then pass
        exp_q.push_back(C_UNMET);
        exp_q.push_back(C_PASS);
        @(negedge clk); req = 1;
        @(negedge clk); req = 0;
        @(negedge clk); eot = 1;
        @(negedge clk); eot = 0; ack = 1;
        @(negedge clk); ack = 0;
        repeat (3) @(negedge clk);
        check(sticky_err_o, 1, "R6 unmet sets sticky");

        check(exp_q.size(), 0, "R1 all expected results seen");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule